// File: doc/BRIEF.md
# Stalled-Address Synchronous RAM

This block is a single-port synchronous RAM. The word width and address width are parameters, and the word count is two to the power of the address width. Every request input is captured by a rank of input registers on the rising clock edge: address, write data, write enable and read enable. The storage array acts on those registered values at the following edge. Reads return the word that was stored before any write in the same cycle.

An address-stall input freezes the registered address. While it is high, reads keep returning the word at the held location, and writes keep landing on it. A parameter selects the read path. The direct path drives the read word straight to the output. The piped path adds one more register. Two asynchronous clears act separately: one on the input registers and one on the read data registers. Their visible timing differs. The stored words are never touched by either clear.

Data moves at a fixed latency with no handshake. The block has no valid or ready signals and never applies back-pressure. A caller must present one request per cycle and take the result the stated number of cycles later.

Top module: `stall_ram`

## Requirements
- R1: Address, write data, write enable and read enable are registered on the rising edge. A read presented before edge k appears on `rdata` after edge k+1 with the direct path (PATH = RD_DIRECT), and not earlier.
- R2: With the piped path (PATH = RD_PIPED), the same read appears one edge later, after edge k+2.
- R3: When `addr_stall` is high at an edge, the registered address keeps its previous value, and reads in those cycles return the word at the held address.
- R4: Writes captured while `addr_stall` is high all land on the held address. The last one wins, and the addresses presented in those cycles are left unchanged.
- R5: When `addr_stall` is low at an edge, the registered address loads the presented address, and the next read uses it.
- R6: A read enable that is low at an edge leaves the read word, and so `rdata`, unchanged.
- R7: A read and a write to the same address in the same cycle return the old word. A later read returns the new word.
- R8: `in_aclr` high immediately zeroes the registered address and both registered enables, and it does not change `rdata` when it is asserted. A read or write captured before the clear is discarded. A stalled read after the clear reads address 0.
- R9: `out_aclr` high forces `rdata` to zero at once, with no clock edge, on both read paths.
- R10: Neither clear alters the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| in_aclr | input | 1 | Asynchronous clear of the input registers, active high |
| out_aclr | input | 1 | Asynchronous clear of the read data registers, active high |
| addr_stall | input | 1 | Hold the registered address at this edge |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| rdata | output | DW | Read data |

## Verification
The case that is hardest to reach from the ports is an input-register clear that arrives while a read and a write are already captured and not yet carried out. Only a clear placed in exactly that cycle shows that both requests are dropped. The stimulus captures a combined read and write to one address, then raises the clear at the following falling edge and holds it across one rising edge. It then issues a stalled read, which must fetch address 0, and finally reads back the target word to show that it was never written. Both read paths are driven side by side with the same stimulus, so every check also compares their one-cycle offset.

// File: rtl/stall_ram_pkg.sv
package stall_ram_pkg;
  // Selects whether the read word passes through an extra register.
  typedef enum logic {
    RD_DIRECT = 1'b0,
    RD_PIPED  = 1'b1
  } rd_path_e;
endpackage

// File: rtl/stall_ram_capture.sv
// Input register rank: every request input is captured on the rising edge.
// The address register can be frozen by the stall input.
module stall_ram_capture #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          in_aclr,
  input  logic          addr_stall,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_wdata,
  output logic          lat_we,
  output logic          lat_re
);

  // Address register: keeps its value while stalled.
  always_ff @(posedge clk or posedge in_aclr) begin
    if (in_aclr) begin
      lat_addr <= '0;
    end else if (!addr_stall) begin
      lat_addr <= addr;
    end
  end

  // Data and enable registers: loaded every edge.
  always_ff @(posedge clk or posedge in_aclr) begin
    if (in_aclr) begin
      lat_wdata <= '0;
      lat_we    <= 1'b0;
      lat_re    <= 1'b0;
    end else begin
      lat_wdata <= wdata;
      lat_we    <= wr_en;
      lat_re    <= rd_en;
    end
  end

endmodule

// File: rtl/stall_ram_core.sv
// Storage array with a synchronous, read-enabled read word register.
// Nonblocking updates give old-data behaviour on same-address read and write.
module stall_ram_core #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          out_aclr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  input  logic          re,
  output logic [DW-1:0] rd_word
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Write port: no reset, contents survive both clears.
  always_ff @(posedge clk) begin
    if (we) begin
      store[addr] <= wdata;
    end
  end

  // Read word register: holds when the read enable is low.
  always_ff @(posedge clk or posedge out_aclr) begin
    if (out_aclr) begin
      rd_word <= '0;
    end else if (re) begin
      rd_word <= store[addr];
    end
  end

endmodule

// File: rtl/stall_ram_outstage.sv
// Read path selection: direct wire or one extra register.
module stall_ram_outstage #(
  parameter int                     DW   = 8,
  parameter stall_ram_pkg::rd_path_e PATH = stall_ram_pkg::RD_DIRECT
) (
  input  logic          clk,
  input  logic          out_aclr,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] rdata
);

  generate
    if (PATH == stall_ram_pkg::RD_PIPED) begin : g_piped
      logic [DW-1:0] pipe_q;
      always_ff @(posedge clk or posedge out_aclr) begin
        if (out_aclr) begin
          pipe_q <= '0;
        end else begin
          pipe_q <= rd_word;
        end
      end
      assign rdata = pipe_q;
    end else begin : g_direct
      assign rdata = rd_word;
    end
  endgenerate

endmodule

// File: rtl/stall_ram.sv
// Single-port synchronous RAM with address stall and split asynchronous clears.
module stall_ram #(
  parameter int                     AW   = 6,
  parameter int                     DW   = 8,
  parameter stall_ram_pkg::rd_path_e PATH = stall_ram_pkg::RD_DIRECT
) (
  input  logic          clk,
  input  logic          in_aclr,
  input  logic          out_aclr,
  input  logic          addr_stall,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [DW-1:0] rdata
);

  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic          lat_we;
  logic          lat_re;
  logic [DW-1:0] rd_word;

  stall_ram_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk        (clk),
    .in_aclr    (in_aclr),
    .addr_stall (addr_stall),
    .addr       (addr),
    .wdata      (wdata),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .lat_addr   (lat_addr),
    .lat_wdata  (lat_wdata),
    .lat_we     (lat_we),
    .lat_re     (lat_re)
  );

  stall_ram_core #(.AW(AW), .DW(DW)) u_core (
    .clk      (clk),
    .out_aclr (out_aclr),
    .addr     (lat_addr),
    .wdata    (lat_wdata),
    .we       (lat_we),
    .re       (lat_re),
    .rd_word  (rd_word)
  );

  stall_ram_outstage #(.DW(DW), .PATH(PATH)) u_outstage (
    .clk      (clk),
    .out_aclr (out_aclr),
    .rd_word  (rd_word),
    .rdata    (rdata)
  );

endmodule

// File: rtl/stall_ram_checker.sv
// Temporal checks on the stalled-address RAM, attached by bind.
module stall_ram_checker #(
  parameter int                     AW   = 6,
  parameter int                     DW   = 8,
  parameter stall_ram_pkg::rd_path_e PATH = stall_ram_pkg::RD_DIRECT
) (
  input logic          clk,
  input logic          in_aclr,
  input logic          out_aclr,
  input logic          addr_stall,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] lat_addr,
  input logic          lat_we,
  input logic          lat_re,
  input logic [DW-1:0] rd_word,
  input logic [DW-1:0] rdata
);

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (in_aclr)
    !addr_stall |=> lat_addr == $past(addr)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (in_aclr)
    addr_stall |=> $stable(lat_addr)); // R3

  AST_INPUT_CLEAR: assert property (@(posedge clk)
    in_aclr |-> (lat_addr == '0 && !lat_we && !lat_re)); // R8

  AST_OUTPUT_CLEAR: assert property (@(posedge clk)
    out_aclr |-> rdata == '0); // R9

  AST_READ_IDLE_HOLD: assert property (@(posedge clk) disable iff (in_aclr || out_aclr)
    !lat_re |=> $stable(rd_word)); // R6

  generate
    if (PATH == stall_ram_pkg::RD_PIPED) begin : g_pipe_chk
      AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (in_aclr || out_aclr)
        1'b1 |=> rdata == $past(rd_word)); // R2
    end
  endgenerate

endmodule

bind stall_ram stall_ram_checker #(.AW(AW), .DW(DW), .PATH(PATH)) u_checker (
  .clk        (clk),
  .in_aclr    (in_aclr),
  .out_aclr   (out_aclr),
  .addr_stall (addr_stall),
  .addr       (addr),
  .lat_addr   (lat_addr),
  .lat_we     (lat_we),
  .lat_re     (lat_re),
  .rd_word    (rd_word),
  .rdata      (rdata)
);

// File: tb/stall_ram_bench.sv
`timescale 1ns/1ps
module stall_ram_bench;
  import stall_ram_pkg::*;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          in_aclr = 1'b0;
  logic          out_aclr = 1'b0;
  logic          addr_stall = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_d;
  logic [DW-1:0] rd_p;

  logic [DW-1:0] model [DEPTH];
  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stall_ram #(.AW(AW), .DW(DW), .PATH(RD_DIRECT)) u_stall_ram (
    .clk(clk), .in_aclr(in_aclr), .out_aclr(out_aclr), .addr_stall(addr_stall),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rd_d)
  );

  stall_ram #(.AW(AW), .DW(DW), .PATH(RD_PIPED)) u_stall_ram_piped (
    .clk(clk), .in_aclr(in_aclr), .out_aclr(out_aclr), .addr_stall(addr_stall),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rd_p)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // Present one request, then wait for the falling edge after its capture.
  task automatic drive(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] wd,
                       input logic re, input logic st);
    addr = a; wr_en = we; wdata = wd; rd_en = re; addr_stall = st;
    @(negedge clk);
  endtask

  task automatic idle();
    drive('0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input string req);
    drive(a, 1'b0, '0, 1'b1, 1'b0);
    idle();
    chk({req, " direct"}, rd_d, model[a]);
    idle();
    chk({req, " piped"}, rd_p, model[a]);
  endtask

  task automatic t_reset();
    in_aclr = 1'b1; out_aclr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset direct", rd_d, '0);
    chk("R9 reset piped", rd_p, '0);
    in_aclr = 1'b0; out_aclr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = DW'(i * 37 + 5);
      drive(AW'(i), 1'b1, model[i], 1'b0, 1'b0);
    end
  endtask

  task automatic t_latency();
    drive(AW'(3), 1'b0, '0, 1'b1, 1'b0);
    chk("R1 not early", rd_d, '0);
    idle();
    chk("R1 direct latency", rd_d, model[3]);
    chk("R2 piped one later", rd_p, '0);
    idle();
    chk("R2 piped latency", rd_p, model[3]);
  endtask

  task automatic t_stall_read();
    drive(AW'(10), 1'b0, '0, 1'b1, 1'b0);
    chk("R3 before", rd_d, model[3]);
    drive(AW'(20), 1'b0, '0, 1'b1, 1'b1);
    chk("R3 first", rd_d, model[10]);
    drive(AW'(30), 1'b0, '0, 1'b1, 1'b1);
    chk("R3 held", rd_d, model[10]);
    drive(AW'(40), 1'b0, '0, 1'b1, 1'b0);
    chk("R3 still held", rd_d, model[10]);
    idle();
    chk("R5 reload", rd_d, model[40]);
    chk("R2 stalled piped", rd_p, model[10]);
    idle();
    chk("R5 reload piped", rd_p, model[40]);
  endtask

  task automatic t_stall_write();
    drive(AW'(50), 1'b1, 8'hA1, 1'b0, 1'b0);
    drive(AW'(51), 1'b1, 8'hB2, 1'b0, 1'b1);
    drive(AW'(52), 1'b1, 8'hC3, 1'b0, 1'b1);
    idle();
    model[50] = 8'hC3;
    rd_check(AW'(50), "R4 held location");
    rd_check(AW'(51), "R4 untouched 51");
    rd_check(AW'(52), "R4 untouched 52");
  endtask

  task automatic t_read_gate();
    rd_check(AW'(20), "R6 setup");
    for (int i = 0; i < 3; i++) begin
      drive(AW'(25), 1'b0, '0, 1'b0, 1'b0);
      chk("R6 hold direct", rd_d, model[20]);
      chk("R6 hold piped", rd_p, model[20]);
    end
  endtask

  task automatic t_rdw();
    logic [DW-1:0] old;
    old = model[7];
    drive(AW'(7), 1'b1, ~old, 1'b1, 1'b0);
    idle();
    chk("R7 old word", rd_d, old);
    model[7] = ~old;
    idle();
    rd_check(AW'(7), "R7 new word");
  endtask

  task automatic t_in_clear();
    rd_check(AW'(5), "R8 setup");
    drive(AW'(9), 1'b1, 8'h5A, 1'b1, 1'b0);
    in_aclr = 1'b1;
    #1;
    chk("R8 no change at clear direct", rd_d, model[5]);
    chk("R8 no change at clear piped", rd_p, model[5]);
    @(negedge clk);
    in_aclr = 1'b0;
    chk("R8 pending read dropped", rd_d, model[5]);
    drive(AW'(33), 1'b0, '0, 1'b1, 1'b1);
    chk("R8 still dropped", rd_d, model[5]);
    idle();
    chk("R8 stalled read at 0", rd_d, model[0]);
    rd_check(AW'(9), "R8 pending write dropped");
    rd_check(AW'(0), "R10 after input clear");
  endtask

  task automatic t_out_clear();
    rd_check(AW'(12), "R9 setup");
    out_aclr = 1'b1;
    #1;
    chk("R9 immediate direct", rd_d, '0);
    chk("R9 immediate piped", rd_p, '0);
    @(negedge clk);
    out_aclr = 1'b0;
    chk("R9 held direct", rd_d, '0);
    idle();
    chk("R9 stays zero piped", rd_p, '0);
    rd_check(AW'(12), "R10 after output clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_latency();
    t_stall_read();
    t_stall_write();
    t_read_gate();
    t_rdw();
    t_in_clear();
    t_out_clear();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule